// File: doc/BRIEF.md
# Emulated Data EEPROM Controller with Unlock Sequence

This block keeps a small non-volatile-style data store of 32 words of 16 bits in flip-flops and lets a processor reach it through byte-wide registers. These are an address register, a control register and eight data bytes that make up four 16-bit staging words. Three operations are offered. A page erase clears a 16-word page. A unit write stores the four staging words into an aligned group of four array words. A single-word read copies one array word into the first staging word.

Write and erase are protected against stray stores. Each must be armed by setting its enable bit on one bus cycle and its trigger bit on the very next cycle. While any operation runs, a stall output holds the processor. Register stores are ignored during that time. When the operation ends, the trigger bit and the enable bit of that operation clear by themselves, so software can poll for completion. Operation lengths are parameters.

Top module: `nvm_shadow_ctrl`

## Requirements
- R1: After reset, every register reads 0, stall is low and every array word reads back as 0.
- R2: Bus offset 0 holds the word address (5 bits) and offset 1 the control register. Staging word k has its low byte at offset 2+2k and its high byte at offset 3+2k. A unit write stores staging words 0..3 into array words 4u..4u+3, where u is address bits 4:2; address bits 1:0 have no effect.
- R3: Control bits are: bit0 read enable, bit1 read trigger, bit2 write enable, bit3 write trigger, bit4 erase enable, bit5 erase trigger. A write or erase trigger starts its operation only if the control store on the directly preceding clock cycle set that operation's enable bit. Otherwise the trigger is dropped, no stall occurs and that enable bit reads 0.
- R4: An erase clears the 16-word page chosen by address bit 4 to zero, whatever address bits 3:0 hold, and leaves the other page unchanged.
- R5: A read trigger stored while the read enable bit already reads 1 copies the array word at the address into staging word 0. A read trigger without that enable starts nothing.
- R6: Stall goes high on the cycle after an accepted trigger. It stays high for exactly ERASE_CYC (64), WRITE_CYC (32) or READ_CYC (4) cycles, depending on the operation, and the trigger bit of the running operation reads 1 exactly while stall is high.
- R7: When an operation ends, its trigger bit and enable bit read 0.
- R8: While stall is high, bus stores to the address, control and data registers have no effect.
- R9: If several trigger bits are accepted in one store, only one operation runs, chosen in the order erase, then write, then read. At most one trigger bit is ever set.
- R10: Staging word 0 keeps its read result for as long as no operation runs and no data register is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register store strobe, one store per cycle |
| busAddr | input | 4 | Register offset for stores and loads |
| busWdata | input | 8 | Store data |
| busRdata | output | 8 | Combinational load data for busAddr |
| stall | output | 1 | High while an operation runs; holds the processor |

## Verification
On every cycle the checker tests a set of rules. Stall may only rise right after a control store carrying a trigger. No more than one trigger bit may be set, and a trigger bit is set exactly while stall is high. Trigger bits must be clear once stall falls. The address register must not change while busy. A failed unlock must leave the enable bit and the trigger bit clear. Some results show only as array contents read back through the register interface, so the directed scenarios cover them: which words a unit write or page erase touches, the value a read returns, the priority among several triggers, the exact stall length of each operation, and the holding of read data.

// File: rtl/nvm_shadow_pkg.sv
package nvm_shadow_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } opState_e;

  // control to datapath strobes
  typedef struct packed {
    logic regWrOk;   // bus stores may land this cycle
    logic doErase;   // final cycle of an erase
    logic doWrite;   // final cycle of a unit write
    logic doRead;    // final cycle of a read
  } dpStrobe_t;

  // control register bit positions
  localparam int CB_RD_EN = 0;
  localparam int CB_RD_GO = 1;
  localparam int CB_WR_EN = 2;
  localparam int CB_WR_GO = 3;
  localparam int CB_ER_EN = 4;
  localparam int CB_ER_GO = 5;

  // bus offsets
  localparam int OFS_ADDR = 0;
  localparam int OFS_CTRL = 1;
  localparam int OFS_DATA = 2;

endpackage

// File: rtl/nvm_shadow_fsm.sv
module nvm_shadow_fsm
  import nvm_shadow_pkg::*;
#(
  parameter int BUS_AW    = 4,
  parameter int ERASE_CYC = 64,
  parameter int WRITE_CYC = 32,
  parameter int READ_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [5:0]        ctrlWdata,
  output logic              stall,
  output logic [7:0]        ctrlReg,
  output dpStrobe_t         strobe
);

  localparam int MAX_EW  = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int MAX_CYC = (MAX_EW > READ_CYC) ? MAX_EW : READ_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  opState_e   state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic       rdEn, rdGo, wrEn, wrGo, erEn, erGo;
  logic       armWrite, armErase;
  logic       ctrlWr, busy, opDone;
  logic       eraseOk, writeOk, readOk;

  assign busy   = (state != ST_IDLE);
  assign ctrlWr = busWe && (busAddr == BUS_AW'(OFS_CTRL)) && !busy;

  always_comb begin
    case (state)
      ST_ERASE: lastCnt = CNT_W'(ERASE_CYC - 1);
      ST_WRITE: lastCnt = CNT_W'(WRITE_CYC - 1);
      ST_READ:  lastCnt = CNT_W'(READ_CYC - 1);
      default:  lastCnt = '0;
    endcase
  end

  assign opDone  = busy && (cnt == lastCnt);
  assign eraseOk = ctrlWdata[CB_ER_GO] && armErase;
  assign writeOk = ctrlWdata[CB_WR_GO] && armWrite;
  assign readOk  = ctrlWdata[CB_RD_GO] && rdEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rdEn     <= 1'b0;
      rdGo     <= 1'b0;
      wrEn     <= 1'b0;
      wrGo     <= 1'b0;
      erEn     <= 1'b0;
      erGo     <= 1'b0;
      armWrite <= 1'b0;
      armErase <= 1'b0;
    end else begin
      armWrite <= 1'b0;
      armErase <= 1'b0;
      if (!busy) begin
        if (ctrlWr) begin
          armWrite <= ctrlWdata[CB_WR_EN];
          armErase <= ctrlWdata[CB_ER_EN];
          rdEn <= ctrlWdata[CB_RD_EN];
          // a trigger without the preceding enable store drops the enable
          wrEn <= ctrlWdata[CB_WR_EN] && !(ctrlWdata[CB_WR_GO] && !armWrite);
          erEn <= ctrlWdata[CB_ER_EN] && !(ctrlWdata[CB_ER_GO] && !armErase);
          cnt  <= '0;
          if (eraseOk) begin
            state <= ST_ERASE;
            erGo  <= 1'b1;
          end else if (writeOk) begin
            state <= ST_WRITE;
            wrGo  <= 1'b1;
          end else if (readOk) begin
            state <= ST_READ;
            rdGo  <= 1'b1;
          end
        end
      end else if (opDone) begin
        state <= ST_IDLE;
        cnt   <= '0;
        case (state)
          ST_ERASE: begin erGo <= 1'b0; erEn <= 1'b0; end
          ST_WRITE: begin wrGo <= 1'b0; wrEn <= 1'b0; end
          default:  begin rdGo <= 1'b0; rdEn <= 1'b0; end
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign stall   = busy;
  assign ctrlReg = {2'b00, erGo, erEn, wrGo, wrEn, rdGo, rdEn};

  always_comb begin
    strobe.regWrOk = !busy;
    strobe.doErase = opDone && (state == ST_ERASE);
    strobe.doWrite = opDone && (state == ST_WRITE);
    strobe.doRead  = opDone && (state == ST_READ);
  end

endmodule

// File: rtl/nvm_shadow_dp.sv
module nvm_shadow_dp
  import nvm_shadow_pkg::*;
#(
  parameter int BUS_AW     = 4,
  parameter int ADDR_W     = 5,
  parameter int PAGE_WORDS = 16,
  parameter int UNIT_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        ctrlReg,
  output logic [7:0]        busRdata,
  output logic [ADDR_W-1:0] addrReg
);

  localparam int WORDS      = 2 ** ADDR_W;
  localparam int PAGE_BITS  = $clog2(PAGE_WORDS);
  localparam int UNIT_BITS  = $clog2(UNIT_WORDS);
  localparam int DATA_BYTES = 2 * UNIT_WORDS;

  logic [7:0]  dataByte [DATA_BYTES];
  logic [15:0] memRd    [WORDS];
  logic [15:0] rdWord;
  logic        regWr;

  assign regWr  = busWe && strobe.regWrOk;
  assign rdWord = memRd[addrReg];

  // address register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (regWr && (busAddr == BUS_AW'(OFS_ADDR))) begin
      addrReg <= busWdata[ADDR_W-1:0];
    end
  end

  // staging bytes; the first word also takes read results
  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataByte[b] <= '0;
      end else if (strobe.doRead && (b < 2)) begin
        dataByte[b] <= (b == 0) ? rdWord[7:0] : rdWord[15:8];
      end else if (regWr && (busAddr == BUS_AW'(OFS_DATA + b))) begin
        dataByte[b] <= busWdata;
      end
    end
  end

  // storage array, one register per word
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    localparam int SLOT = g % UNIT_WORDS;
    logic [15:0] word;
    logic        inPage, inUnit;

    assign inPage = (addrReg >> PAGE_BITS) == (IDX >> PAGE_BITS);
    assign inUnit = (addrReg >> UNIT_BITS) == (IDX >> UNIT_BITS);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        word <= '0;
      end else if (strobe.doErase && inPage) begin
        word <= '0;
      end else if (strobe.doWrite && inUnit) begin
        word <= {dataByte[2*SLOT+1], dataByte[2*SLOT]};
      end
    end

    assign memRd[g] = word;
  end

  // load mux
  always_comb begin
    busRdata = '0;
    if (busAddr == BUS_AW'(OFS_ADDR)) busRdata = 8'(addrReg);
    if (busAddr == BUS_AW'(OFS_CTRL)) busRdata = ctrlReg;
    for (int b = 0; b < DATA_BYTES; b++) begin
      if (busAddr == BUS_AW'(OFS_DATA + b)) busRdata = dataByte[b];
    end
  end

endmodule

// File: rtl/nvm_shadow_ctrl.sv
module nvm_shadow_ctrl
  import nvm_shadow_pkg::*;
#(
  parameter int BUS_AW     = 4,
  parameter int ADDR_W     = 5,
  parameter int PAGE_WORDS = 16,
  parameter int UNIT_WORDS = 4,
  parameter int ERASE_CYC  = 64,
  parameter int WRITE_CYC  = 32,
  parameter int READ_CYC   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              stall
);

  dpStrobe_t         strobe;
  logic [7:0]        ctrlReg;
  logic [ADDR_W-1:0] addrReg;

  nvm_shadow_fsm #(
    .BUS_AW(BUS_AW), .ERASE_CYC(ERASE_CYC),
    .WRITE_CYC(WRITE_CYC), .READ_CYC(READ_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .ctrlWdata(busWdata[5:0]), .stall(stall), .ctrlReg(ctrlReg),
    .strobe(strobe)
  );

  nvm_shadow_dp #(
    .BUS_AW(BUS_AW), .ADDR_W(ADDR_W),
    .PAGE_WORDS(PAGE_WORDS), .UNIT_WORDS(UNIT_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe), .ctrlReg(ctrlReg),
    .busRdata(busRdata), .addrReg(addrReg)
  );

endmodule

// File: rtl/nvm_shadow_ctrl_chk.sv
module nvm_shadow_ctrl_chk #(
  parameter int BUS_AW = 4,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [BUS_AW-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              stall,
  input logic [7:0]        ctrlReg,
  input logic [ADDR_W-1:0] addrReg
);

  logic [7:0] goBits;
  logic       ctrlStore;
  assign goBits    = ctrlReg & 8'h2A;
  assign ctrlStore = busWe && (busAddr == BUS_AW'(1)) && !stall;

  // R6: stall only follows a control store that carried a trigger
  assert_stall_from_trigger_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(ctrlStore && ((busWdata & 8'h2A) != 8'h00)));

  // R6: a trigger bit is set exactly while busy
  assert_go_tracks_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (goBits != 8'h00) == stall);

  // R7: no trigger bit survives completion
  assert_done_clears_go_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> (goBits == 8'h00));

  // R8: address register frozen while busy
  assert_busy_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(addrReg));

  // R9: at most one trigger bit
  assert_single_go_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(goBits));

  // R3: write trigger without a directly preceding enable store fails
  assert_write_unlock_fail_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStore && busWdata[3] && !$past(ctrlStore && busWdata[2]))
      |=> (!ctrlReg[2] && !ctrlReg[3]));

  // R3: same for erase
  assert_erase_unlock_fail_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStore && busWdata[5] && !$past(ctrlStore && busWdata[4]))
      |=> (!ctrlReg[4] && !ctrlReg[5]));

endmodule

bind nvm_shadow_ctrl nvm_shadow_ctrl_chk #(.BUS_AW(BUS_AW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .stall(stall), .ctrlReg(ctrlReg), .addrReg(addrReg)
);

// File: tb/tb_nvm_shadow_ctrl.sv
module tb_nvm_shadow_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       stall;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nvm_shadow_ctrl dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .stall(stall)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
  endtask

  task automatic busIdle();
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (stall && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic writeUnit(input logic [4:0] a, input logic [15:0] w [4], output int n);
    busWr(4'd0, 8'(a));
    for (int k = 0; k < 4; k++) begin
      busWr(4'(2 + 2*k), w[k][7:0]);
      busWr(4'(3 + 2*k), w[k][15:8]);
    end
    busWr(4'd1, 8'h04);
    busWr(4'd1, 8'h0C);
    busIdle();
    waitDone(n);
  endtask

  task automatic readWord(input logic [4:0] a, output logic [15:0] w, output int n);
    logic [7:0] lo, hi;
    busWr(4'd0, 8'(a));
    busWr(4'd1, 8'h01);
    busWr(4'd1, 8'h03);
    busIdle();
    waitDone(n);
    rdReg(4'd2, lo);
    rdReg(4'd3, hi);
    w = {hi, lo};
  endtask

  task automatic eraseAt(input logic [4:0] a, output int n);
    busWr(4'd0, 8'(a));
    busWr(4'd1, 8'h10);
    busWr(4'd1, 8'h30);
    busIdle();
    waitDone(n);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    logic [15:0] w;
    int n;
    check("R1 stall", int'(stall), 0);
    for (int a = 0; a < 10; a++) begin
      rdReg(4'(a), v);
      check("R1 register", int'(v), 0);
    end
    readWord(5'd9, w, n);
    check("R1 array word", int'(w), 0);
  endtask

  task automatic t_write();
    logic [15:0] w [4];
    logic [15:0] r;
    logic [7:0] v;
    int n;
    w[0] = 16'hA1B2; w[1] = 16'hC3D4; w[2] = 16'hE5F6; w[3] = 16'h0718;
    writeUnit(5'd5, w, n);
    check("R6 write length", n, 32);
    rdReg(4'd1, v);
    check("R7 ctrl after write", int'(v), 0);
    for (int k = 0; k < 4; k++) begin
      readWord(5'(4 + k), r, n);
      check("R2 unit word", int'(r), int'(w[k]));
    end
    check("R6 read length", n, 4);
    rdReg(4'd1, v);
    check("R7 ctrl after read", int'(v), 0);
    w[0] = 16'h1111; w[1] = 16'h2222; w[2] = 16'h3333; w[3] = 16'h4444;
    writeUnit(5'h1F, w, n);
    readWord(5'd28, r, n);
    check("R2 low bits ignored", int'(r), 16'h1111);
    readWord(5'd31, r, n);
    check("R2 last word", int'(r), 16'h4444);
    readWord(5'd3, r, n);
    check("R2 neighbour untouched", int'(r), 0);
  endtask

  task automatic t_unlock_fail();
    logic [7:0] v;
    logic [15:0] r;
    int n;
    busWr(4'd0, 8'd4);
    busWr(4'd2, 8'h55);
    busWr(4'd1, 8'h04);
    busIdle();
    busWr(4'd1, 8'h0C);
    busIdle();
    check("R3 no stall after gap", int'(stall), 0);
    rdReg(4'd1, v);
    check("R3 enable dropped", int'(v), 0);
    busWr(4'd1, 8'h0C);
    busIdle();
    check("R3 no stall single store", int'(stall), 0);
    readWord(5'd4, r, n);
    check("R3 array unchanged", int'(r), 16'hA1B2);
  endtask

  task automatic t_erase();
    logic [15:0] r;
    int n;
    eraseAt(5'h13, n);
    check("R6 erase length", n, 64);
    readWord(5'd28, r, n);
    check("R4 page cleared", int'(r), 0);
    readWord(5'd5, r, n);
    check("R4 other page kept", int'(r), 16'hC3D4);
    eraseAt(5'h0A, n);
    readWord(5'd4, r, n);
    check("R4 page 0 cleared", int'(r), 0);
  endtask

  task automatic t_priority();
    logic [15:0] w [4];
    logic [15:0] r;
    logic [7:0] v;
    int n;
    w[0] = 16'h9ABC; w[1] = 16'h1234; w[2] = 16'h5678; w[3] = 16'hDEF0;
    writeUnit(5'h10, w, n);
    busWr(4'd2, 8'h77);
    busWr(4'd3, 8'h66);
    busWr(4'd1, 8'h14);
    busWr(4'd1, 8'h3C);
    busIdle();
    rdReg(4'd1, v);
    check("R9 only erase trigger", int'(v & 8'h2A), 8'h20);
    waitDone(n);
    check("R9 erase length wins", n, 64);
    rdReg(4'd1, v);
    check("R7 erase bits cleared", int'(v & 8'h3A), 0);
    readWord(5'h10, r, n);
    check("R9 write not run", int'(r), 0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] w [4];
    logic [15:0] r;
    logic [7:0] v;
    int n;
    w[0] = 16'h0F0F; w[1] = 16'h1E1E; w[2] = 16'h2D2D; w[3] = 16'h3C3C;
    busWr(4'd0, 8'h0C);
    for (int k = 0; k < 4; k++) begin
      busWr(4'(2 + 2*k), w[k][7:0]);
      busWr(4'(3 + 2*k), w[k][15:8]);
    end
    busWr(4'd1, 8'h04);
    busWr(4'd1, 8'h0C);
    busWr(4'd0, 8'h00);
    busWr(4'd2, 8'hEE);
    busWr(4'd1, 8'h30);
    busIdle();
    waitDone(n);
    rdReg(4'd0, v);
    check("R8 address kept", int'(v), 8'h0C);
    rdReg(4'd2, v);
    check("R8 data kept", int'(v), 8'h0F);
    rdReg(4'd1, v);
    check("R8 control store ignored", int'(v), 0);
    readWord(5'd13, r, n);
    check("R8 write landed", int'(r), 16'h1E1E);
  endtask

  task automatic t_read_hold();
    logic [15:0] r;
    logic [7:0] lo, hi;
    int n;
    readWord(5'd14, r, n);
    check("R5 read value", int'(r), 16'h2D2D);
    repeat (20) @(negedge clk);
    rdReg(4'd2, lo);
    rdReg(4'd3, hi);
    check("R10 data held", int'({hi, lo}), 16'h2D2D);
    busWr(4'd0, 8'd12);
    busWr(4'd1, 8'h02);
    busIdle();
    check("R5 no stall without enable", int'(stall), 0);
    @(negedge clk);
    rdReg(4'd2, lo);
    rdReg(4'd3, hi);
    check("R5 data unchanged", int'({hi, lo}), 16'h2D2D);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_unlock_fail();
    t_erase();
    t_priority();
    t_busy_ignore();
    t_read_hold();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule